// File: doc/BRIEF.md
# Self-clocked serial port for a sampling converter

This block is the serial port of a sampling converter that acts as bus master. It makes its own frame sync and serial clock instead of taking them from the host. The serial clock runs from an internal phase that toggles on every `clk` edge, so one serial-clock period is two `clk` periods. A falling edge on the active-low start input begins a conversion and raises `busy`. The following rising edge arms a frame. A short, fixed time later `sync_n` falls, and during that frame of 16 serial-clock periods the result word leaves on `dout` while a control word for the next conversion enters on `din`.

The result shifted out during a conversion belongs to that same conversion. The control word captured during a frame is presented on `ctrl_word` only once the frame ends, so it takes effect for the conversion after it. A mode input selects a free-running serial clock or a clock that runs only inside a frame. A polarity input selects which serial-clock edge launches and samples data. A calibration input holds the serial clock idle.

Top module: `conv_serial_master`

## Requirements
- R1: With `cont_mode`=1, `sclk` follows the internal phase and changes level on every `clk` edge. With `cont_mode`=0, `sclk` stays at its inactive level whenever `sync_n` is high.
- R2: A falling edge on `conv_start_n` while the block is idle raises `busy` on the next `clk` edge.
- R3: `sync_n` falls 2 or 3 `clk` edges after the block registers the rising edge of `conv_start_n`. It falls only on an edge that leaves `sclk` at its inactive level.
- R4: A frame holds exactly 16 active `sclk` edges. On the next `sclk` edge after the 16th, `sync_n` rises and `busy` falls together.
- R5: `dout` carries bit 15 of the loaded word from the edge where `sync_n` falls. Each active edge then moves it to the next lower bit, so data leaves MSB first. Bit 0 holds until the frame ends.
- R6: `din` is sampled on each of the 16 active edges, MSB first. `ctrl_word` takes the assembled word on the edge where `sync_n` rises, and changes at no other time.
- R7: `result_word` is captured on the edge where `sync_n` falls, so the word read out belongs to the conversion in progress.
- R8: `edge_pol`=0 makes the rising `sclk` edge active and gives `sclk` a low idle level. `edge_pol`=1 makes the falling edge active and gives a high idle level.
- R9: While `cal_busy` is high, `sclk` sits at its inactive level from the next `clk` edge onward, and the serial-clock phase is frozen.
- R10: A falling edge on `conv_start_n` while `busy` is high is ignored. No second frame follows, and `busy` stays low once the current frame ends.
- R11: A synchronous reset sets `sync_n` high, `busy` low, `dout` to 0 and `ctrl_word` to 0, and clears both shift registers.
- R12: The output shift register is cleared when a frame ends, so `dout` is 0 once `sync_n` rises. `dout_oe` is high exactly while `sync_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cont_mode | input | 1 | 1 = free-running serial clock, 0 = clock only inside a frame |
| edge_pol | input | 1 | Active serial-clock edge select (0 rising, 1 falling) |
| cal_busy | input | 1 | Calibration in progress; holds the serial clock idle |
| conv_start_n | input | 1 | Active-low conversion start |
| din | input | 1 | Serial control data in |
| result_word | input | 16 | Conversion result to shift out |
| sclk | output | 1 | Serial clock produced by the block |
| sync_n | output | 1 | Active-low frame sync produced by the block |
| busy | output | 1 | Conversion in progress |
| dout | output | 1 | Serial result data out |
| dout_oe | output | 1 | Output enable for `dout` (low models high impedance) |
| ctrl_word | output | 16 | Control word captured in the last completed frame |

## Verification
The bench targets the frame boundary. A design with an off-by-one in its edge count would shift 15 or 17 bits, or would keep `sync_n` low across a 17th active edge in free-running mode. It also runs every combination of clock mode and polarity. A design that counted the wrong edge would deliver the result word shifted by one bit, or would return a corrupted control word. A start pulse sent in mid-frame checks that the block does not open a second conversion on its own. A calibration window checks that the serial clock really goes quiet, rather than carrying on from its free-running phase.

// File: rtl/csm_pkg.sv
package csm_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_HOLD  = 2'd1,
    SEQ_ARM   = 2'd2,
    SEQ_FRAME = 2'd3
  } seq_st_t;
endpackage

// File: rtl/sclk_phase.sv
// Internal serial-clock phase; active/inactive strobes mark the clk edge
// at which the phase moves onto the active or inactive level.
module sclk_phase (
  input  logic clk,
  input  logic rst,
  input  logic cal_busy,
  input  logic edge_pol,
  output logic ph,
  output logic cal_q,
  output logic act_stb,
  output logic inact_stb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= 1'b0;
      cal_q <= 1'b0;
    end else begin
      cal_q <= cal_busy;
      if (!cal_q) ph <= ~ph;
    end
  end

  // The inactive level equals edge_pol; leaving it is the active edge.
  assign act_stb   = !cal_q && (ph == edge_pol);
  assign inact_stb = !cal_q && (ph != edge_pol);
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import csm_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int ARM_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic conv_start_n,
  input  logic act_stb,
  input  logic inact_stb,
  output logic sync_n,
  output logic busy,
  output logic load,
  output logic shift,
  output logic samp,
  output logic fin
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int DLY_W = $clog2(ARM_CYC + 1);

  seq_st_t          st;
  logic             conv_q;
  logic [DLY_W-1:0] dly;
  logic [CNT_W-1:0] bits;
  logic             conv_fall, conv_rise, dly_done, in_frame;

  assign conv_fall = conv_q & ~conv_start_n;
  assign conv_rise = ~conv_q & conv_start_n;
  assign dly_done  = (dly == DLY_W'(ARM_CYC - 1));
  assign in_frame  = (st == SEQ_FRAME);

  assign load  = (st == SEQ_ARM) && dly_done && inact_stb;
  assign samp  = in_frame && act_stb && (bits < CNT_W'(WORD_W));
  assign shift = in_frame && act_stb && (bits < CNT_W'(WORD_W - 1));
  assign fin   = in_frame && inact_stb && (bits == CNT_W'(WORD_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SEQ_IDLE;
      conv_q <= 1'b1;
      dly    <= '0;
      bits   <= '0;
      sync_n <= 1'b1;
      busy   <= 1'b0;
    end else begin
      conv_q <= conv_start_n;
      unique case (st)
        SEQ_IDLE: if (conv_fall) begin
          busy <= 1'b1;
          st   <= SEQ_HOLD;
        end
        SEQ_HOLD: if (conv_rise) begin
          dly <= '0;
          st  <= SEQ_ARM;
        end
        SEQ_ARM: begin
          if (!dly_done) dly <= dly + 1'b1;
          if (load) begin
            sync_n <= 1'b0;
            bits   <= '0;
            st     <= SEQ_FRAME;
          end
        end
        SEQ_FRAME: begin
          if (samp) bits <= bits + 1'b1;
          if (fin) begin
            sync_n <= 1'b1;
            busy   <= 1'b0;
            st     <= SEQ_IDLE;
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic              samp,
  input  logic              fin,
  input  logic [WORD_W-1:0] result_word,
  input  logic              din,
  output logic              dout,
  output logic [WORD_W-1:0] ctrl_word
);
  logic [WORD_W-1:0] tx_sr, rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr     <= '0;
      rx_sr     <= '0;
      ctrl_word <= '0;
    end else begin
      if (load)       tx_sr <= result_word;
      else if (shift) tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
      else if (fin)   tx_sr <= '0;
      if (samp) rx_sr <= {rx_sr[WORD_W-2:0], din};
      if (fin)  ctrl_word <= rx_sr;
    end
  end

  assign dout = tx_sr[WORD_W-1];
endmodule

// File: rtl/conv_serial_master.sv
module conv_serial_master #(
  parameter int WORD_W  = 16,
  parameter int ARM_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cont_mode,
  input  logic              edge_pol,
  input  logic              cal_busy,
  input  logic              conv_start_n,
  input  logic              din,
  input  logic [WORD_W-1:0] result_word,
  output logic              sclk,
  output logic              sync_n,
  output logic              busy,
  output logic              dout,
  output logic              dout_oe,
  output logic [WORD_W-1:0] ctrl_word
);
  logic ph, cal_q, act_stb, inact_stb;
  logic load, shift, samp, fin;

  sclk_phase u_phase (
    .clk(clk), .rst(rst), .cal_busy(cal_busy), .edge_pol(edge_pol),
    .ph(ph), .cal_q(cal_q), .act_stb(act_stb), .inact_stb(inact_stb)
  );

  frame_seq #(.WORD_W(WORD_W), .ARM_CYC(ARM_CYC)) u_seq (
    .clk(clk), .rst(rst), .conv_start_n(conv_start_n),
    .act_stb(act_stb), .inact_stb(inact_stb),
    .sync_n(sync_n), .busy(busy), .load(load), .shift(shift),
    .samp(samp), .fin(fin)
  );

  word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .shift(shift), .samp(samp),
    .fin(fin), .result_word(result_word), .din(din),
    .dout(dout), .ctrl_word(ctrl_word)
  );

  // Gated mode keeps sclk idle outside a frame; calibration idles it always.
  assign sclk    = cal_q ? edge_pol : ((cont_mode || !sync_n) ? ph : edge_pol);
  assign dout_oe = ~sync_n;
endmodule

// File: rtl/conv_serial_master_chk.sv
module conv_serial_master_chk #(
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rst,
  input logic cont_mode,
  input logic edge_pol,
  input logic cal_busy,
  input logic conv_start_n,
  input logic sclk,
  input logic sync_n,
  input logic busy,
  input logic dout
);
  logic       sclk_q;
  logic [7:0] act_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      act_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      if (sync_n) act_cnt <= '0;
      else if (sclk != sclk_q && sclk != edge_pol) act_cnt <= act_cnt + 1'b1;
    end
  end

  assert_gated_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!cont_mode && sync_n) |-> (sclk == edge_pol));
  assert_busy_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(conv_start_n));
  assert_sync_on_idle_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_n) |-> (sclk == edge_pol));
  assert_frame_len_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> (act_cnt == 8'(WORD_W)));
  assert_busy_end_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> $fell(busy));
  assert_cal_idle_R9: assert property (@(posedge clk) disable iff (rst)
    cal_busy |=> (sclk == edge_pol));
  assert_tx_cleared_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> (dout == 1'b0));
endmodule

bind conv_serial_master conv_serial_master_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .cont_mode(cont_mode), .edge_pol(edge_pol),
  .cal_busy(cal_busy), .conv_start_n(conv_start_n), .sclk(sclk),
  .sync_n(sync_n), .busy(busy), .dout(dout)
);

// File: tb/conv_serial_master_bench.sv
`timescale 1ns/1ps
module conv_serial_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cont_mode = 1'b1, edge_pol = 1'b0, cal_busy = 1'b0;
  logic        conv_start_n = 1'b1, din = 1'b0;
  logic [15:0] result_word = '0;
  logic        sclk, sync_n, busy, dout, dout_oe;
  logic [15:0] ctrl_word;

  int checks = 0, errors = 0, cyc = 0;

  conv_serial_master u_conv_serial_master (
    .clk(clk), .rst(rst), .cont_mode(cont_mode), .edge_pol(edge_pol),
    .cal_busy(cal_busy), .conv_start_n(conv_start_n), .din(din),
    .result_word(result_word), .sclk(sclk), .sync_n(sync_n), .busy(busy),
    .dout(dout), .dout_oe(dout_oe), .ctrl_word(ctrl_word)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: events derived from the requirements.
  bit          m_ph, m_cal, m_cq, m_sync, m_busy;
  int          m_state, m_wait, m_edges;
  logic [15:0] m_tx, m_rx, m_ctrl;

  always @(posedge clk) begin
    bit act, inact, fall, rise;
    if (rst) begin
      m_ph = 0; m_cal = 0; m_cq = 1; m_sync = 1; m_busy = 0;
      m_state = 0; m_wait = 0; m_edges = 0;
      m_tx = '0; m_rx = '0; m_ctrl = '0;
    end else begin
      act   = !m_cal && (m_ph == edge_pol);
      inact = !m_cal && (m_ph != edge_pol);
      fall  = m_cq && !conv_start_n;
      rise  = !m_cq && conv_start_n;
      case (m_state)
        0: if (fall) begin m_busy = 1; m_state = 1; end
        1: if (rise) begin m_state = 2; m_wait = 0; end
        2: if (m_wait >= 1 && inact) begin
             m_state = 3; m_sync = 0; m_edges = 0; m_tx = result_word;
           end else m_wait++;
        default: if (act && m_edges < 16) begin
             m_rx = {m_rx[14:0], din};
             if (m_edges < 15) m_tx = m_tx << 1;
             m_edges++;
           end else if (inact && m_edges == 16) begin
             m_sync = 1; m_busy = 0; m_state = 0; m_ctrl = m_rx; m_tx = '0;
           end
      endcase
      if (!m_cal) m_ph = !m_ph;
      m_cal = cal_busy;
      m_cq  = conv_start_n;
    end
  end

  always @(negedge clk) begin
    logic exp_sclk;
    if (!rst) begin
      exp_sclk = m_cal ? edge_pol : ((cont_mode || !m_sync) ? m_ph : edge_pol);
      chk(sclk == exp_sclk, "R1/R8 sclk", sclk, exp_sclk);
      chk(sync_n == m_sync, "R3/R4 sync_n", sync_n, m_sync);
      chk(busy == m_busy, "R2 busy", busy, m_busy);
      chk(dout == m_tx[15], "R5 dout", dout, m_tx[15]);
      chk(dout_oe == !m_sync, "R12 dout_oe", dout_oe, !m_sync);
      chk(ctrl_word == m_ctrl, "R6 ctrl_word", ctrl_word, m_ctrl);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Host side: drive din and read dout while sclk rests at its idle level.
  task automatic run_frame(input logic [15:0] res, input logic [15:0] w,
                           input bit glitch, output logic [15:0] got);
    int  i = 0;
    bit  seen = 0;
    got = '0;
    result_word = res;
    @(negedge clk) conv_start_n = 1'b0;
    repeat (2) @(negedge clk);
    conv_start_n = 1'b1;
    for (int g = 0; g < 300; g++) begin
      @(negedge clk);
      if (!sync_n) seen = 1;
      if (seen && sync_n) break;
      if (!sync_n && sclk == edge_pol && i < 16) begin
        got[15-i] = dout;
        din = w[15-i];
        i++;
        if (glitch && i == 5) conv_start_n = 1'b0;  // start pulse mid-frame (R10)
        if (glitch && i == 9) conv_start_n = 1'b1;
      end
    end
    chk(seen && sync_n, "R4 frame completed", {31'd0, sync_n}, 32'd1);
    chk(i == 16, "R4 idle-level slots", i, 16);
  endtask

  initial begin
    logic [15:0] got, res, w;
    repeat (4) @(negedge clk);
    chk(sync_n == 1'b1, "R11 sync_n reset", sync_n, 1);
    chk(busy == 1'b0, "R11 busy reset", busy, 0);
    chk(dout == 1'b0, "R11 dout reset", dout, 0);
    chk(ctrl_word == 16'h0, "R11 ctrl_word reset", ctrl_word, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    for (int k = 0; k < 4; k++) begin
      cont_mode = ~k[0];
      edge_pol  = k[1];
      res = 16'hA5C3 ^ (16'h1111 * k[15:0]);
      w   = 16'h8001 | (16'h3C00 >> k);
      repeat (3) @(negedge clk);
      run_frame(res, w, 1'b0, got);
      chk(got == res, "R5/R7 result word read out", got, res);
      @(negedge clk);
      chk(ctrl_word == w, "R6 control word captured", ctrl_word, w);
    end

    // Start pulse during a frame is ignored (R10).
    cont_mode = 1'b1; edge_pol = 1'b0;
    run_frame(16'h7E18, 16'h0F0F, 1'b1, got);
    chk(got == 16'h7E18, "R10 frame unaffected by extra start", got, 16'h7E18);
    repeat (8) @(negedge clk);
    chk(busy == 1'b0, "R10 no second conversion", busy, 0);
    chk(sync_n == 1'b1, "R10 no second frame", sync_n, 1);
    chk(dout == 1'b0, "R12 dout cleared after frame", dout, 0);

    // Calibration idles the serial clock in free-running mode (R9).
    for (int p = 0; p < 2; p++) begin
      edge_pol = p[0];
      @(negedge clk) cal_busy = 1'b1;
      @(negedge clk);
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        chk(sclk == edge_pol, "R9 sclk idle during calibration", sclk, edge_pol);
      end
      cal_busy = 1'b0;
      repeat (3) @(negedge clk);
    end

    edge_pol = 1'b0; cont_mode = 1'b0;
    run_frame(16'h0001, 16'hFFFE, 1'b0, got);
    chk(got == 16'h0001, "R5 LSB-only result", got, 16'h0001);
    @(negedge clk);
    chk(ctrl_word == 16'hFFFE, "R6 pipeline control update", ctrl_word, 16'hFFFE);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule